// File: doc/BRIEF.md
# Host Buffer RAM Port Controller

This block gives a microprocessor access to two byte-organised transfer buffers through one 16-bit programmed-I/O data port. One buffer is isochronous and split into two banks that alternate with the frame timing. The other is a single asynchronous buffer. Before a transfer the processor loads a byte count. It then writes a command code once, and that code picks the buffer and the direction. After that it makes as many 16-bit data strobes as it needs. Each strobe moves two bytes and advances an internal byte pointer by two.

When an access brings the pointer up to the programmed count, the block raises an end-of-transfer flag in an interrupt status register. It also updates a buffer status word. On each start-of-frame pulse the processor-side isochronous bank changes over, unless both banks are already marked full. In that case the processor stays on bank 1. Both buffers are held as internal byte arrays. `BUF_BYTES` must be a power of two.

Top module: `hbuf_port_ctrl`

## Requirements
- R1: Command codes select the target. 0x40 is an isochronous read, 0xC0 an isochronous write, 0x41 an asynchronous read and 0xC1 an asynchronous write. Any other code deselects both buffers, and data strobes that follow it have no effect.
- R2: Every command write returns the byte pointer to 0. Any number of data strobes may follow a single command.
- R3: A data strobe whose direction matches the command moves two bytes and adds 2 to the pointer. The low port byte maps to the even address and the high byte to the next odd address. Read data is on `dat_rdata` from the clock edge that samples `dat_rd`.
- R4: `cnt_wr` loads the byte count. The end-of-transfer event fires on the access after which the pointer is at or above the count, clamped to `BUF_BYTES`. Transfer of ceil(count/2) words therefore completes a transfer. A count of 0 never completes.
- R5: Bit 2 of `int_status` is set by end-of-transfer and cleared by `int_wr` with `int_wdata[2]`=1. Writing 0 to that bit leaves it set. The other bits stay 0.
- R6: A matching-direction strobe with the pointer at or past the count is ignored. A write leaves the RAM unchanged, a read returns 0x0000, and the pointer holds. A strobe in the direction opposite to the command is ignored, and `dat_rdata` holds its value.
- R7: `buf_status` bit 0 is isochronous bank 0 full, bit 1 is bank 1 full, and bit 2 is asynchronous transfer done. An isochronous write transfer that completes sets the flag of the current bank. `iso_consume[i]` clears flag i. An asynchronous end-of-transfer sets bit 2, and a new asynchronous command clears it.
- R8: Each `sof` pulse toggles `iso_bank`. When both full flags are set, `sof` does not toggle, and `iso_bank` reads 1 so that the processor reaches bank 1.
- R9: After reset, `iso_bank`, `int_status`, `buf_status` and `dat_rdata` are 0 and no buffer is selected.
- R10: The two isochronous banks and the asynchronous buffer are separate storage. Data written to one is not seen in another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command code write strobe |
| cmd_code | input | 8 | Command code |
| cnt_wr | input | 1 | Transfer count write strobe |
| cnt_wdata | input | PTR_W | Transfer count in bytes |
| dat_wr | input | 1 | Data port write strobe |
| dat_wdata | input | 16 | Data port write word |
| dat_rd | input | 1 | Data port read strobe |
| dat_rdata | output | 16 | Data port read word |
| int_wr | input | 1 | Interrupt status write (one clears) |
| int_wdata | input | 8 | Interrupt status clear mask |
| int_status | output | 8 | Interrupt status, bit 2 end-of-transfer |
| buf_status | output | 3 | Bank 0 full, bank 1 full, async done |
| sof | input | 1 | Start-of-frame pulse |
| iso_consume | input | 2 | Per-bank full flag clear pulses |
| iso_bank | output | 1 | Processor-side isochronous bank |

## Verification
A pointer that steps wrongly or starts from a stale value shows up at once in two places. The end-of-transfer bit rises on the wrong strobe, and a read-back word comes from the wrong position. The bench sweeps the count from 0 to 16 to catch any such fault within a few strobes. A faulty beyond-count guard corrupts earlier data, and a later read-back of the prefill exposes it. A bank selector that toggles while both banks are full, or that stores into the wrong bank, returns the other bank's words on the first read after the next frame pulse.

// File: rtl/hbuf_pkg.sv
package hbuf_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_ISO  = 2'd1,
    TGT_ASY  = 2'd2
  } hbuf_tgt_e;

  localparam logic [7:0] CMD_ISO_RD = 8'h40;
  localparam logic [7:0] CMD_ISO_WR = 8'hC0;
  localparam logic [7:0] CMD_ASY_RD = 8'h41;
  localparam logic [7:0] CMD_ASY_WR = 8'hC1;
endpackage

// File: rtl/hbuf_byte_ram.sv
module hbuf_byte_ram #(
  parameter int NBYTES = 64,
  localparam int ADDR_W = $clog2(NBYTES)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata
);
  logic [7:0] mem [NBYTES];
  logic [ADDR_W-1:0] addr_even;
  logic [ADDR_W-1:0] addr_odd;

  assign addr_even = {addr[ADDR_W-1:1], 1'b0};
  assign addr_odd  = {addr[ADDR_W-1:1], 1'b1};

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr_even] <= wdata[7:0];
      mem[addr_odd]  <= wdata[15:8];
    end
  end

  assign rdata = {mem[addr_odd], mem[addr_even]};
endmodule

// File: rtl/hbuf_xfer_ctrl.sv
module hbuf_xfer_ctrl
  import hbuf_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  localparam int PTR_W = $clog2(BUF_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [7:0]       cmd_code,
  input  logic             cnt_wr,
  input  logic [PTR_W-1:0] cnt_wdata,
  input  logic             dat_wr,
  input  logic             dat_rd,
  output hbuf_tgt_e        tgt,
  output logic             dir_wr,
  output logic             acc_go,
  output logic             acc_beyond,
  output logic [PTR_W-1:0] ptr,
  output logic             eot,
  output logic             asy_cmd
);
  localparam logic [PTR_W-1:0] LIM = PTR_W'(BUF_BYTES);

  hbuf_tgt_e        tgt_q, tgt_nx;
  logic             dir_q, dir_nx;
  logic [PTR_W-1:0] ptr_q, ptr_nx;
  logic [PTR_W-1:0] cnt_q, cnt_nx;
  logic [PTR_W-1:0] cnt_lim;
  logic [PTR_W-1:0] ptr_step;
  logic             attempt;
  logic             in_range;

  assign cnt_lim  = (cnt_q > LIM) ? LIM : cnt_q;
  assign ptr_step = ptr_q + PTR_W'(2);
  assign attempt  = (tgt_q != TGT_NONE) && !cmd_wr && (dir_q ? dat_wr : dat_rd);
  assign in_range = (ptr_q < cnt_lim);
  assign acc_go     = attempt && in_range;
  assign acc_beyond = attempt && !in_range;
  assign eot        = acc_go && (ptr_step >= cnt_lim);

  always_comb begin
    tgt_nx  = tgt_q;
    dir_nx  = dir_q;
    ptr_nx  = ptr_q;
    cnt_nx  = cnt_q;
    asy_cmd = 1'b0;
    if (cnt_wr) cnt_nx = cnt_wdata;
    if (cmd_wr) begin
      ptr_nx = '0;
      dir_nx = cmd_code[7];
      unique case (cmd_code)
        CMD_ISO_RD, CMD_ISO_WR: tgt_nx = TGT_ISO;
        CMD_ASY_RD, CMD_ASY_WR: begin
          tgt_nx  = TGT_ASY;
          asy_cmd = 1'b1;
        end
        default: tgt_nx = TGT_NONE;
      endcase
    end else if (acc_go) begin
      ptr_nx = ptr_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= TGT_NONE;
      dir_q <= 1'b0;
      ptr_q <= '0;
      cnt_q <= '0;
    end else begin
      tgt_q <= tgt_nx;
      dir_q <= dir_nx;
      ptr_q <= ptr_nx;
      cnt_q <= cnt_nx;
    end
  end

  assign tgt    = tgt_q;
  assign dir_wr = dir_q;
  assign ptr    = ptr_q;

  AST_PTR_EVEN: assert property (@(posedge clk) disable iff (!rst_n) ptr_q[0] == 1'b0); // R3
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    acc_go |=> ptr_q == $past(ptr_q) + PTR_W'(2)); // R3
  AST_CMD_CLEARS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> ptr_q == '0); // R2
  AST_BEYOND_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    acc_beyond |=> $stable(ptr_q)); // R6
  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n) ptr_q <= LIM); // R4
endmodule

// File: rtl/hbuf_iso_bank.sv
module hbuf_iso_bank #(
  parameter int NBANK = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  logic [NBANK-1:0] consume,
  input  logic             set_full,
  output logic [NBANK-1:0] full,
  output logic             bank_eff
);
  logic [NBANK-1:0] full_q, full_nx;
  logic             bank_q, bank_nx;
  logic             both_full;

  assign both_full = &full_q;
  assign bank_eff  = both_full | bank_q;

  genvar gi;
  generate
    for (gi = 0; gi < NBANK; gi++) begin : g_flag
      always_comb begin
        full_nx[gi] = full_q[gi];
        if (consume[gi]) full_nx[gi] = 1'b0;
        if (set_full && (bank_eff == gi[0])) full_nx[gi] = 1'b1;
      end
    end
  endgenerate

  always_comb begin
    bank_nx = bank_q;
    if (sof) bank_nx = both_full ? 1'b1 : ~bank_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0;
      bank_q <= 1'b0;
    end else begin
      full_q <= full_nx;
      bank_q <= bank_nx;
    end
  end

  assign full = full_q;

  AST_BOTH_FULL_NO_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && both_full) |=> bank_q); // R8
  AST_SOF_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && !both_full) |=> bank_q != $past(bank_q)); // R8
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_full && consume == '0) |=> $stable(full_q)); // R7
endmodule

// File: rtl/hbuf_port_ctrl.sv
module hbuf_port_ctrl
  import hbuf_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  localparam int PTR_W = $clog2(BUF_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [7:0]       cmd_code,
  input  logic             cnt_wr,
  input  logic [PTR_W-1:0] cnt_wdata,
  input  logic             dat_wr,
  input  logic [15:0]      dat_wdata,
  input  logic             dat_rd,
  output logic [15:0]      dat_rdata,
  input  logic             int_wr,
  input  logic [7:0]       int_wdata,
  output logic [7:0]       int_status,
  output logic [2:0]       buf_status,
  input  logic             sof,
  input  logic [1:0]       iso_consume,
  output logic             iso_bank
);
  localparam int EOT_BIT = 2;

  hbuf_tgt_e        tgt;
  logic             dir_wr, acc_go, acc_beyond, eot, asy_cmd;
  logic [PTR_W-1:0] ptr;
  logic [1:0]       full;
  logic             bank_eff;
  logic [15:0]      iso_rd, asy_rd;
  logic             iso_we, asy_we;

  logic [15:0] rdata_q, rdata_nx;
  logic [7:0]  st_q, st_nx;
  logic        adone_q, adone_nx;

  hbuf_xfer_ctrl #(.BUF_BYTES(BUF_BYTES)) u_xfer (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(cmd_wr), .cmd_code(cmd_code),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .dat_wr(dat_wr), .dat_rd(dat_rd),
    .tgt(tgt), .dir_wr(dir_wr),
    .acc_go(acc_go), .acc_beyond(acc_beyond),
    .ptr(ptr), .eot(eot), .asy_cmd(asy_cmd)
  );

  hbuf_iso_bank #(.NBANK(2)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .sof(sof), .consume(iso_consume),
    .set_full(eot && dir_wr && (tgt == TGT_ISO)),
    .full(full), .bank_eff(bank_eff)
  );

  assign iso_we = acc_go && dir_wr && (tgt == TGT_ISO);
  assign asy_we = acc_go && dir_wr && (tgt == TGT_ASY);

  hbuf_byte_ram #(.NBYTES(2 * BUF_BYTES)) u_iso_ram (
    .clk(clk), .we(iso_we),
    .addr({bank_eff, ptr[PTR_W-2:0]}),
    .wdata(dat_wdata), .rdata(iso_rd)
  );

  hbuf_byte_ram #(.NBYTES(BUF_BYTES)) u_asy_ram (
    .clk(clk), .we(asy_we),
    .addr(ptr[PTR_W-2:0]),
    .wdata(dat_wdata), .rdata(asy_rd)
  );

  always_comb begin
    rdata_nx = rdata_q;
    if (!dir_wr && acc_go)     rdata_nx = (tgt == TGT_ISO) ? iso_rd : asy_rd;
    if (!dir_wr && acc_beyond) rdata_nx = '0;
  end

  always_comb begin
    st_nx = st_q;
    if (int_wr) st_nx = st_nx & ~int_wdata;
    if (eot)    st_nx[EOT_BIT] = 1'b1;
  end

  always_comb begin
    adone_nx = adone_q;
    if (asy_cmd) adone_nx = 1'b0;
    if (eot && (tgt == TGT_ASY)) adone_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      st_q    <= '0;
      adone_q <= 1'b0;
    end else begin
      rdata_q <= rdata_nx;
      st_q    <= st_nx;
      adone_q <= adone_nx;
    end
  end

  assign dat_rdata  = rdata_q;
  assign int_status = st_q;
  assign buf_status = {adone_q, full};
  assign iso_bank   = bank_eff;

  AST_EOT_FLAGS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    eot |=> int_status[EOT_BIT]); // R4
  AST_BEYOND_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_beyond && !dir_wr) |=> dat_rdata == 16'h0000); // R6
  AST_NO_WRITE_BEYOND: assert property (@(posedge clk) disable iff (!rst_n)
    acc_beyond |-> !(iso_we || asy_we)); // R6
  AST_ASY_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (eot && tgt == TGT_ASY) |=> buf_status[2]); // R7
endmodule

// File: tb/tb_hbuf_port_ctrl.sv
module tb_hbuf_port_ctrl;
  localparam int BUF_BYTES = 64;
  localparam int PTR_W = $clog2(BUF_BYTES) + 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_wr = 1'b0;
  logic [7:0]       cmd_code = '0;
  logic             cnt_wr = 1'b0;
  logic [PTR_W-1:0] cnt_wdata = '0;
  logic             dat_wr = 1'b0;
  logic [15:0]      dat_wdata = '0;
  logic             dat_rd = 1'b0;
  logic [15:0]      dat_rdata;
  logic             int_wr = 1'b0;
  logic [7:0]       int_wdata = '0;
  logic [7:0]       int_status;
  logic [2:0]       buf_status;
  logic             sof = 1'b0;
  logic [1:0]       iso_consume = '0;
  logic             iso_bank;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  hbuf_port_ctrl #(.BUF_BYTES(BUF_BYTES)) dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(cmd_wr), .cmd_code(cmd_code),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .dat_wr(dat_wr), .dat_wdata(dat_wdata),
    .dat_rd(dat_rd), .dat_rdata(dat_rdata),
    .int_wr(int_wr), .int_wdata(int_wdata), .int_status(int_status),
    .buf_status(buf_status), .sof(sof), .iso_consume(iso_consume),
    .iso_bank(iso_bank)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [7:0] c);
    cmd_wr = 1'b1; cmd_code = c;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic do_cnt(input int c);
    cnt_wr = 1'b1; cnt_wdata = PTR_W'(c);
    @(negedge clk); cnt_wr = 1'b0;
  endtask

  task automatic do_wr(input logic [15:0] d);
    dat_wr = 1'b1; dat_wdata = d;
    @(negedge clk); dat_wr = 1'b0;
  endtask

  task automatic do_rd(output logic [15:0] d);
    dat_rd = 1'b1;
    @(negedge clk); dat_rd = 1'b0;
    d = dat_rdata;
  endtask

  task automatic clr_int(input logic [7:0] m);
    int_wr = 1'b1; int_wdata = m;
    @(negedge clk); int_wr = 1'b0;
  endtask

  task automatic pulse_sof();
    sof = 1'b1;
    @(negedge clk); sof = 1'b0;
  endtask

  task automatic consume(input logic [1:0] m);
    iso_consume = m;
    @(negedge clk); iso_consume = '0;
  endtask

  function automatic logic [15:0] pat(input int base, input int i);
    return 16'(base + i * 16'h0101);
  endfunction

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    int first;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 iso_bank", int'(iso_bank), 0);
    check("R9 int_status", int'(int_status), 0);
    check("R9 buf_status", int'(buf_status), 0);
    check("R9 dat_rdata", int'(dat_rdata), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: nothing selected, write strobe has no effect on status
    do_cnt(2); do_wr(16'hFFFF);
    check("R9 no select eot", int'(int_status), 0);

    // R4 count sweep: completion after ceil(c/2) words, never for 0
    for (int c = 0; c <= 16; c++) begin
      do_cnt(c);
      do_cmd(8'hC1);
      first = 0;
      for (int k = 1; k <= 10; k++) begin
        do_wr(16'h1234);
        if (int_status[2] && first == 0) first = k;
      end
      check($sformatf("R4 eot strobe count c=%0d", c), first, (c + 1) / 2);
      clr_int(8'h04);
    end

    // R5 write-one-to-clear
    do_cnt(2); do_cmd(8'hC1); do_wr(16'h0);
    check("R5 set", int'(int_status), 4);
    clr_int(8'h00);
    check("R5 zero write keeps", int'(int_status), 4);
    clr_int(8'hFB);
    check("R5 other mask keeps", int'(int_status), 4);
    clr_int(8'h04);
    check("R5 cleared", int'(int_status), 0);

    // R6 prefill 8 words, overwrite with count 12 (last two ignored)
    do_cnt(16); do_cmd(8'hC1);
    for (int i = 0; i < 8; i++) do_wr(pat(16'h1100, i));
    do_cnt(12); do_cmd(8'hC1);
    for (int i = 0; i < 8; i++) do_wr(pat(16'h8800, i));
    check("R7 async done", int'(buf_status[2]), 1);
    do_cnt(16); do_cmd(8'h41);
    check("R7 async done cleared by cmd", int'(buf_status[2]), 0);
    for (int i = 0; i < 8; i++) begin
      do_rd(rd);
      check($sformatf("R3 R6 readback word %0d", i), int'(rd),
            int'(i < 6 ? pat(16'h8800, i) : pat(16'h1100, i)));
    end
    do_rd(rd);
    check("R6 read beyond is zero", int'(rd), 0);
    clr_int(8'h04);

    // R2 R6 opposite direction ignored, rdata holds
    do_cmd(8'h41);
    do_rd(rd);
    check("R2 restart read word0", int'(rd), int'(pat(16'h8800, 0)));
    do_wr(16'hDEAD);
    check("R6 wrong dir rdata holds", int'(dat_rdata), int'(pat(16'h8800, 0)));
    do_rd(rd);
    check("R6 wrong dir ptr holds", int'(rd), int'(pat(16'h8800, 1)));
    // R1 unknown code deselects
    do_cmd(8'h55); do_wr(16'hBEEF); do_wr(16'hBEEF);
    do_cmd(8'h41); do_rd(rd);
    check("R1 invalid code no write", int'(rd), int'(pat(16'h8800, 0)));
    clr_int(8'h04);

    // R7 R8 R10 isochronous banks
    do_cnt(8); do_cmd(8'hC0);
    for (int i = 0; i < 4; i++) do_wr(pat(16'hA000, i));
    check("R7 bank0 full", int'(buf_status), 1);
    pulse_sof();
    check("R8 sof toggles", int'(iso_bank), 1);
    do_cmd(8'hC0);
    for (int i = 0; i < 4; i++) do_wr(pat(16'hB000, i));
    check("R7 both full", int'(buf_status), 3);
    pulse_sof();
    check("R8 both full no toggle", int'(iso_bank), 1);
    pulse_sof();
    check("R8 both full stays bank1", int'(iso_bank), 1);
    consume(2'b10);
    check("R7 consume bank1", int'(buf_status), 1);
    check("R8 bank after consume", int'(iso_bank), 1);
    do_cmd(8'h40);
    for (int i = 0; i < 4; i++) begin
      do_rd(rd);
      check($sformatf("R10 bank1 word %0d", i), int'(rd), int'(pat(16'hB000, i)));
    end
    check("R7 iso read leaves flags", int'(buf_status), 1);
    pulse_sof();
    check("R8 toggle back", int'(iso_bank), 0);
    do_cmd(8'h40);
    for (int i = 0; i < 4; i++) begin
      do_rd(rd);
      check($sformatf("R10 bank0 word %0d", i), int'(rd), int'(pat(16'hA000, i)));
    end
    consume(2'b01);
    check("R7 consume bank0", int'(buf_status), 0);
    do_cnt(16); do_cmd(8'h41); do_rd(rd);
    check("R10 async untouched by iso", int'(rd), int'(pat(16'h8800, 0)));

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule